// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers completion pulses from several on-board engines and falling edges on handshake lines into one host interrupt line. It has one 32-bit control/status word. The low field is a per-source enable mask. The middle field latches which sources raised the pending interrupt. The top bit is a write-only qualifier, and it decides what a host write does.

When the host writes with the qualifier set, the write loads the enable mask and the pending state is kept. When the host writes with the qualifier clear, the write acknowledges the interrupt. It clears the latched sources and the interrupt line, and leaves the mask as it was. A service routine can therefore dismiss an interrupt with a single write. Handshake lines come from another clock domain. Each passes through a two-flop synchronizer and then a falling-edge detector. A line counts as a source only when its mode bit selects interrupt use and its output-enable is off.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the enable field, the status field and `irq_o` are all 0, and `rd_data_o` reads 0.
- R2: A write with `wr_data_i[31]`=1 loads the enable field, `rd_data_o[14:0]`, from `wr_data_i[14:0]`. Reserved bits [14:11] always read 0.
- R3: A write with `wr_data_i[31]`=0 clears the status field and `irq_o` after the clock edge that captures it. The enable field does not change.
- R4: Source bit positions are: handshake lines at bits 0 to 5, step completion at 6, countdown completion at 7, readback completion at 8, over-current at 9 and DMA completion at 10. An enabled source that is active in a cycle sets its status bit, `rd_data_o[16+k]`, and raises `irq_o` at the next edge.
- R5: An event whose enable bit is 0 is ignored. It sets no status bit and does not raise `irq_o`.
- R6: With its mode bit at 1 and its output-enable at 0, a high-to-low transition on handshake line i sets status bit i on the third rising clock edge after the change.
- R7: A handshake line raises no event on a rising edge. It also raises none on a falling edge while its output-enable is 1 or its mode bit is 0.
- R8: While an interrupt is pending, further enabled events OR into the status field, and `irq_o` stays high until a clearing write.
- R9: An enabled event in the same cycle as a clearing write is kept. After that edge the status field holds only that event.
- R10: Read bit 31 (the write qualifier) and bit 15 always read 0.
- R11: A write that loads the enable field leaves pending status bits and `irq_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the control word |
| wr_data_i | input | 32 | Host write data; bit 31 selects mask load (1) or acknowledge (0) |
| rd_data_o | output | 32 | Read view: {0, status[14:0], 0, enable[14:0]} |
| hs_line_i | input | 6 | Asynchronous handshake lines |
| hs_intr_mode_i | input | 6 | Per-line interrupt mode select |
| hs_oe_i | input | 6 | Per-line output-enable; 1 blocks the line as a source |
| step_done_i | input | 1 | Step-sequence completion pulse |
| count_done_i | input | 1 | Countdown completion pulse |
| rdbk_done_i | input | 1 | Readback completion pulse |
| over_curr_i | input | 1 | Over-current event pulse |
| dma_done_i | input | 1 | DMA completion pulse |
| irq_o | output | 1 | Host interrupt, high while any status bit is set |

## Verification
The bench targets events that land in the same cycle as a clearing write. A design that let the clear win would lose that event. It also checks accumulation of two sources while an interrupt is pending; a design that overwrote the status instead of ORing into it would report only the last source. Handshake timing is checked to the exact edge, which exposes a missing or extra synchronizer stage. Rising edges and lines with the output-enable set or the mode bit cleared must stay silent, which exposes a level-sensitive detector or a missing qualifier. Mask loads must keep the pending state, and reserved enable bits must read as zero.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned SRC_W   = 15;
  localparam int unsigned NUM_HS  = 6;
  localparam int unsigned BIT_STEP  = NUM_HS;
  localparam int unsigned BIT_COUNT = NUM_HS + 1;
  localparam int unsigned BIT_RDBK  = NUM_HS + 2;
  localparam int unsigned BIT_OVC   = NUM_HS + 3;
  localparam int unsigned BIT_DMA   = NUM_HS + 4;
  localparam int unsigned USED_W    = NUM_HS + 5;
  localparam int unsigned ST_LSB    = 16;
  localparam int unsigned WE_BIT    = 31;
  localparam logic [SRC_W-1:0] USED_MASK = SRC_W'((1 << USED_W) - 1);
endpackage

// File: rtl/hs_fall_detect.sv
module hs_fall_detect #(
  parameter int unsigned N      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], line_i[i]};
        prev_q <= sync_q[LAST];
      end
    end

    assign fall_o[i] = prev_q & ~sync_q[LAST];
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import evt_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_we_i,
  input  logic [SRC_W-1:0] wr_mask_i,
  input  logic [SRC_W-1:0] src_evt_i,
  output logic [SRC_W-1:0] enable_o,
  output logic [SRC_W-1:0] status_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] enable_q, status_q, status_d, hits;
  logic             ack;

  assign ack  = wr_en_i & ~wr_we_i;
  assign hits = src_evt_i & enable_q;

  // events in the acknowledge cycle survive the clear
  always_comb begin
    status_d = ack ? '0 : status_q;
    status_d = status_d | hits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      status_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (wr_en_i && wr_we_i) enable_q <= wr_mask_i & USED_MASK;
      status_q <= status_d;
      irq_o    <= |status_d;
    end
  end

  assign enable_o = enable_q;
  assign status_o = status_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [NUM_HS-1:0] hs_line_i,
  input  logic [NUM_HS-1:0] hs_intr_mode_i,
  input  logic [NUM_HS-1:0] hs_oe_i,
  input  logic              step_done_i,
  input  logic              count_done_i,
  input  logic              rdbk_done_i,
  input  logic              over_curr_i,
  input  logic              dma_done_i,
  output logic              irq_o
);
  logic [NUM_HS-1:0] hs_fall;
  logic [SRC_W-1:0]  src_evt, enable, status;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i[WE_BIT-1:SRC_W];

  hs_fall_detect #(.N(NUM_HS), .STAGES(SYNC_STAGES)) u_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (hs_line_i),
    .fall_o (hs_fall)
  );

  always_comb begin
    src_evt                = '0;
    src_evt[NUM_HS-1:0]    = hs_fall & hs_intr_mode_i & ~hs_oe_i;
    src_evt[BIT_STEP]      = step_done_i;
    src_evt[BIT_COUNT]     = count_done_i;
    src_evt[BIT_RDBK]      = rdbk_done_i;
    src_evt[BIT_OVC]       = over_curr_i;
    src_evt[BIT_DMA]       = dma_done_i;
  end

  irq_mask_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_we_i   (wr_data_i[WE_BIT]),
    .wr_mask_i (wr_data_i[SRC_W-1:0]),
    .src_evt_i (src_evt),
    .enable_o  (enable),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  assign rd_data_o = {1'b0, status, 1'b0, enable};
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [31:0]      wr_data_i,
  input logic [SRC_W-1:0] src_evt_i,
  input logic [31:0]      rd_data_o,
  input logic             irq_o
);
  logic [SRC_W-1:0] en_v, st_v;
  assign en_v = rd_data_o[SRC_W-1:0];
  assign st_v = rd_data_o[ST_LSB +: SRC_W];

  // R2
  a_r2_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[WE_BIT] |=>
      en_v == ($past(wr_data_i[SRC_W-1:0]) & USED_MASK));

  // R3
  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_data_i[WE_BIT] && ((src_evt_i & en_v) == '0) |=>
      st_v == '0 && !irq_o);

  // R3
  a_r3_ack_keeps_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_data_i[WE_BIT] |=> $stable(en_v));

  // R4
  a_r4_hit_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_evt_i & en_v) != '0 |=> irq_o);

  // R5
  a_r5_masked_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_evt_i & ~en_v) != '0 && (src_evt_i & en_v) == '0 && !wr_en_i |=>
      $stable(st_v));

  // R8
  a_r8_sticky_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(wr_en_i && !wr_data_i[WE_BIT]) |=> irq_o);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .src_evt_i (src_evt),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o)
);

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;
  typedef struct {
    logic [31:0] rd;
    logic        irq;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [5:0]  hs_line = 6'h3F;
  logic [5:0]  hs_mode = 6'h00;
  logic [5:0]  hs_oe = 6'h00;
  logic        step_d = 0, cnt_d = 0, rdbk_d = 0, ovc_d = 0, dma_d = 0;
  logic        irq;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  evt_irq_ctrl uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .wr_en_i        (wr_en),
    .wr_data_i      (wr_data),
    .rd_data_o      (rd_data),
    .hs_line_i      (hs_line),
    .hs_intr_mode_i (hs_mode),
    .hs_oe_i        (hs_oe),
    .step_done_i    (step_d),
    .count_done_i   (cnt_d),
    .rdbk_done_i    (rdbk_d),
    .over_curr_i    (ovc_d),
    .dma_done_i     (dma_d),
    .irq_o          (irq)
  );

  function automatic logic [31:0] view(logic [14:0] en, logic [14:0] st);
    return {1'b0, st, 1'b0, en};
  endfunction

  // monitor: checks each queued item just after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (rd_data !== e.rd || irq !== e.irq) begin
          n_fail++;
          $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                   e.tag, rd_data, irq, e.rd, e.irq);
        end
      end
    end
  end

  task automatic expect_now(logic [14:0] en, logic [14:0] st, string tag);
    exp_t e;
    e.rd = view(en, st);
    e.irq = (st != 0);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic host_wr(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic pulse(logic [4:0] sel);
    @(negedge clk);
    {dma_d, ovc_d, rdbk_d, cnt_d, step_d} = sel;
    @(negedge clk);
    {dma_d, ovc_d, rdbk_d, cnt_d, step_d} = '0;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #10000000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    expect_now(15'h0, 15'h0, "R1 reset state");

    host_wr(32'hFFFF_FFFF);
    expect_now(15'h07FF, 15'h0, "R2 mask load, reserved bits read 0; R10 bits 31/15 zero");

    pulse(5'b00001);
    expect_now(15'h07FF, 15'h0040, "R4 step completion at bit 6");

    pulse(5'b10000);
    expect_now(15'h07FF, 15'h0440, "R8 dma ORs into pending status");

    host_wr(32'h8000_07FF);
    expect_now(15'h07FF, 15'h0440, "R11 mask load keeps pending status");

    host_wr(32'h0000_1234);
    expect_now(15'h07FF, 15'h0, "R3 ack clears status, mask kept");

    host_wr(32'h8000_077F);
    expect_now(15'h077F, 15'h0, "R2 mask with bit 7 off");
    pulse(5'b00010);
    expect_now(15'h077F, 15'h0, "R5 disabled countdown ignored");

    pulse(5'b01100);
    expect_now(15'h077F, 15'h0300, "R4 readback bit 8 and over-current bit 9");

    // acknowledge in the same cycle as a DMA pulse
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0; dma_d = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; dma_d = 1'b0;
    expect_now(15'h077F, 15'h0400, "R9 event coinciding with ack is kept");
    host_wr(32'h0);
    expect_now(15'h077F, 15'h0, "R3 second ack clears");

    // handshake lines
    hs_mode = 6'h3F;
    hs_oe = 6'h00;
    settle(4);
    expect_now(15'h077F, 15'h0, "R7 lines idle high after reset raise nothing");

    @(negedge clk);
    hs_line[2] = 1'b0;
    @(negedge clk);
    begin
      exp_t e;
      e.rd = view(15'h077F, 15'h0); e.irq = 1'b0; e.tag = "R6 no status on second edge";
      q.push_back(e);
    end
    @(negedge clk);
    begin
      exp_t e;
      e.rd = view(15'h077F, 15'h0004); e.irq = 1'b1; e.tag = "R6 line 2 fall on third edge";
      q.push_back(e);
    end
    settle(2);
    host_wr(32'h0);
    expect_now(15'h077F, 15'h0, "R3 ack after handshake");

    @(negedge clk);
    hs_line[2] = 1'b1;
    settle(5);
    expect_now(15'h077F, 15'h0, "R7 rising edge ignored");

    hs_oe[3] = 1'b1;
    @(negedge clk);
    hs_line[3] = 1'b0;
    settle(5);
    expect_now(15'h077F, 15'h0, "R7 output-enabled line ignored");

    hs_mode[4] = 1'b0;
    @(negedge clk);
    hs_line[4] = 1'b0;
    settle(5);
    expect_now(15'h077F, 15'h0, "R7 line with mode off ignored");

    @(negedge clk);
    hs_line[5] = 1'b0;
    settle(5);
    expect_now(15'h077F, 15'h0020, "R6 line 5 fall sets bit 5");

    host_wr(32'h8000_0000);
    expect_now(15'h0, 15'h0020, "R11 clearing mask keeps pending bit");

    settle(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule